// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode. Fetch hands it blocks of eight 16-bit parcels. Each block comes with the address of its first parcel and an offset that says where useful parcels begin. The aligner cuts the parcel stream into whole instructions of one, two, three or four parcels. The length of each instruction is read from the low bits of its first parcel. Each cycle it offers up to four instructions in program order on a valid/ready output.

Parcels that do not yet form a complete instruction stay in an internal parcel queue. When fetch moves on, the new block's parcels are appended behind them. This lets an instruction that straddles a block or line boundary be rebuilt without a gap. A flush input drops everything held, so that a redirected fetch can restart at any parcel of its first block.

Start positions are found by a serial chain across the four output slots. Each link needs only the length of the instruction before it. If decode stalls, the block holds its output and stops taking fetch blocks, and no parcel is lost.

Top module: `vl_insn_aligner`

## Requirements
- R1: The length code of a slot is taken from its first parcel `p`:
  - 0 (one parcel) when `p[1:0]` is not 2'b11;
  - 1 (two parcels) when `p[1:0]` is 2'b11 and `p[4:2]` is not 3'b111;
  - 2 (three parcels) when `p[5:0]` is 6'b011111;
  - 3 (four parcels) when `p[6:0]` is 7'b0111111.
- R2: A first parcel with `p[6:0]` equal to 7'b1111111 sets the slot's illegal flag, reports length code 0 and consumes one parcel.
- R3: A slot's 64-bit instruction field holds its parcels zero-extended. The first parcel is in bits 15:0, the next in bits 31:16, and so on.
- R4: Up to four slots are valid at once, always as a prefix from slot 0, in program order. A slot's address is the byte address of its first parcel, advancing by 2 per parcel.
- R5: An instruction whose parcels are not all present is not emitted. It is held and emitted complete once the following block supplies the rest.
- R6: In an accepted block, parcels below the start offset are dropped. After a flush, the first slot's address is the block address plus twice the offset.
- R7: During a flush cycle, out_valid_o and fb_ready_o are low. All held parcels are discarded.
- R8: fb_ready_o is high exactly when no flush is present and the parcel queue holds at most 8 parcels.
- R9: While out_valid_o is high and out_ready_i low, no parcel is consumed. Slot 0 keeps its instruction and address into the next cycle.
- R10: After reset, out_valid_o is low and fb_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Drop all held parcels (redirect) |
| fb_valid_i | input | 1 | Fetch block present |
| fb_ready_o | output | 1 | Fetch block accepted this cycle if valid |
| fb_data_i | input | PARCELS*16 | Parcels, parcel 0 in bits 15:0 |
| fb_addr_i | input | ADDR_W | Byte address of parcel 0 of the block |
| fb_off_i | input | log2(PARCELS) | Index of first parcel to use |
| out_valid_o | output | 1 | At least one slot holds an instruction |
| out_ready_i | input | 1 | Decode takes all valid slots |
| slot_valid_o | output | SLOTS | Per-slot valid |
| slot_insn_o | output | SLOTS*64 | Zero-extended instructions |
| slot_len_o | output | SLOTS*2 | Length codes |
| slot_bad_o | output | SLOTS | Illegal-length flags |
| slot_addr_o | output | SLOTS*ADDR_W | First-parcel byte addresses |

## Verification
The bench uses the default build: eight-parcel blocks, four slots and 32-bit addresses. That gives a sixteen-parcel queue, so a block is accepted only when eight or fewer parcels are held.

A synthetic program stream mixes all four lengths with illegal first parcels. Redirects land at random offsets, sometimes mid-instruction. Together these reach instructions split across two blocks, a full four-slot output, and a queue whose contents are blocked by fetch back-pressure.

Three phases vary decode readiness: a long stall phase holds slot 0 for many cycles, and a free-running phase drains the stream at full width.

// File: rtl/vl_align_pkg.sv
package vl_align_pkg;

  typedef logic [15:0] parcel_t;

  // length code from the first parcel: 0..3 means 1..4 parcels
  function automatic logic [1:0] len_code(input parcel_t p);
    if (p[1:0] != 2'b11)      return 2'd0;
    else if (p[4:2] != 3'b111) return 2'd1;
    else if (!p[5])            return 2'd2;
    else if (!p[6])            return 2'd3;
    else                       return 2'd0;
  endfunction

  function automatic logic len_bad(input parcel_t p);
    return p[6:0] == 7'h7f;
  endfunction

  // parcels consumed by the instruction starting with p
  function automatic logic [2:0] parcel_span(input parcel_t p);
    if (len_bad(p)) return 3'd1;
    return {1'b0, len_code(p)} + 3'd1;
  endfunction

endpackage

// File: rtl/vl_align_scan.sv
module vl_align_scan
  import vl_align_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  parcel_t          win   [DEPTH],
  input  logic [CNT_W-1:0] avail,
  output logic [SLOTS-1:0] vld,
  output logic [CNT_W-1:0] pos   [SLOTS],
  output logic [1:0]       len   [SLOTS],
  output logic [SLOTS-1:0] bad,
  output logic [63:0]      insn  [SLOTS],
  output logic [CNT_W-1:0] used
);

  localparam int PW    = CNT_W + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic [PW-1:0] start [SLOTS+1];
  logic          ok    [SLOTS+1];

  assign start[0] = '0;
  assign ok[0]    = 1'b1;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    parcel_t       head;
    logic [2:0]    span;
    logic [PW-1:0] endp;

    assign head = (start[k] < PW'(DEPTH)) ? win[start[k][IDX_W-1:0]] : '0;
    assign span = parcel_span(head);
    assign endp = start[k] + PW'(span);

    // only the span of the previous instruction flows down the chain
    assign vld[k]     = ok[k] && (start[k] < PW'(avail)) && (endp <= PW'(avail));
    assign ok[k+1]    = vld[k];
    assign start[k+1] = vld[k] ? endp : start[k];

    assign pos[k] = start[k][CNT_W-1:0];
    assign len[k] = len_code(head);
    assign bad[k] = len_bad(head);

    always_comb begin
      insn[k] = '0;
      for (int j = 0; j < 4; j++) begin
        logic [PW-1:0] at;
        at = start[k] + PW'(j);
        if (j < int'(span) && at < PW'(DEPTH))
          insn[k][16*j +: 16] = win[at[IDX_W-1:0]];
      end
    end

    if (k > 0) begin : g_chk
      p_slot_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld[k] |-> vld[k-1]);
    end
  end

  assign used = start[SLOTS][CNT_W-1:0];

endmodule

// File: rtl/vl_align_queue.sv
module vl_align_queue
  import vl_align_pkg::*;
#(
  parameter int PARCELS = 8,
  parameter int DEPTH   = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OFF_W  = $clog2(PARCELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic [CNT_W-1:0]        pop_i,
  input  logic                    push_i,
  input  logic [PARCELS*16-1:0]   blk_i,
  input  logic [OFF_W-1:0]        off_i,
  output parcel_t                 q_o   [DEPTH],
  output logic [CNT_W-1:0]        cnt_o
);

  localparam int IDX_W = $clog2(DEPTH);

  parcel_t          q    [DEPTH];
  parcel_t          nq   [DEPTH];
  logic [CNT_W-1:0] cnt, ncnt, keep;

  assign keep = cnt - pop_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [CNT_W:0] s;
      int             r;
      s = (CNT_W+1)'(i) + {1'b0, pop_i};
      nq[i] = (s < (CNT_W+1)'(DEPTH)) ? q[s[IDX_W-1:0]] : '0;
      r = i - int'(keep) + int'(off_i);
      if (push_i && i >= int'(keep) && r < PARCELS)
        nq[i] = blk_i[r*16 +: 16];
    end
    if (flush_i)     ncnt = '0;
    else if (push_i) ncnt = keep + CNT_W'(PARCELS) - CNT_W'(off_i);
    else             ncnt = keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt <= ncnt;
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
    end
  end

  assign q_o   = q;
  assign cnt_o = cnt;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> cnt == '0);

endmodule

// File: rtl/vl_insn_aligner.sv
module vl_insn_aligner
  import vl_align_pkg::*;
#(
  parameter int PARCELS = 8,
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 32,
  localparam int DEPTH  = 2 * PARCELS,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OFF_W  = $clog2(PARCELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic                    fb_valid_i,
  output logic                    fb_ready_o,
  input  logic [PARCELS*16-1:0]   fb_data_i,
  input  logic [ADDR_W-1:0]       fb_addr_i,
  input  logic [OFF_W-1:0]        fb_off_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [SLOTS-1:0]        slot_valid_o,
  output logic [SLOTS*64-1:0]     slot_insn_o,
  output logic [SLOTS*2-1:0]      slot_len_o,
  output logic [SLOTS-1:0]        slot_bad_o,
  output logic [SLOTS*ADDR_W-1:0] slot_addr_o
);

  parcel_t          win   [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [SLOTS-1:0] vld, bad;
  logic [CNT_W-1:0] pos   [SLOTS];
  logic [1:0]       len   [SLOTS];
  logic [63:0]      insn  [SLOTS];
  logic [CNT_W-1:0] used, pop;
  logic             fire, accept, reseat;
  logic [ADDR_W-1:0] head_addr;

  assign out_valid_o = !flush_i && vld[0];
  assign fire        = out_valid_o && out_ready_i;
  assign pop         = fire ? used : '0;
  assign fb_ready_o  = !flush_i && (cnt <= CNT_W'(PARCELS));
  assign accept      = fb_valid_i && fb_ready_o;
  assign reseat      = accept && (cnt == pop);

  vl_align_queue #(.PARCELS(PARCELS), .DEPTH(DEPTH)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush_i(flush_i),
    .pop_i  (pop),
    .push_i (accept),
    .blk_i  (fb_data_i),
    .off_i  (fb_off_i),
    .q_o    (win),
    .cnt_o  (cnt)
  );

  vl_align_scan #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_scan (
    .clk  (clk),
    .rst_n(rst_n),
    .win  (win),
    .avail(cnt),
    .vld  (vld),
    .pos  (pos),
    .len  (len),
    .bad  (bad),
    .insn (insn),
    .used (used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      head_addr <= '0;
    else if (reseat) head_addr <= fb_addr_i + ADDR_W'({fb_off_i, 1'b0});
    else if (fire)   head_addr <= head_addr + ADDR_W'({used, 1'b0});
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_out
    assign slot_valid_o[k]             = out_valid_o && vld[k];
    assign slot_insn_o[k*64 +: 64]     = insn[k];
    assign slot_len_o[k*2 +: 2]        = len[k];
    assign slot_bad_o[k]               = bad[k];
    assign slot_addr_o[k*ADDR_W +: ADDR_W] = head_addr + ADDR_W'({pos[k], 1'b0});
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(slot_insn_o[63:0]) && $stable(slot_addr_o[ADDR_W-1:0])));

  p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !reseat) |=> head_addr == $past(head_addr + ADDR_W'({used, 1'b0})));

endmodule

// File: tb/vl_insn_aligner_tb.sv
module vl_insn_aligner_tb_top;

  localparam int NP   = 8;
  localparam int NS   = 4;
  localparam int AW   = 32;
  localparam int NBLK = 128;
  localparam int MEMP = NBLK * NP;
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0;
  logic fb_valid_i = 1'b0;
  logic fb_ready_o;
  logic [NP*16-1:0] fb_data_i = '0;
  logic [AW-1:0] fb_addr_i = '0;
  logic [2:0] fb_off_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [NS-1:0] slot_valid_o;
  logic [NS*64-1:0] slot_insn_o;
  logic [NS*2-1:0] slot_len_o;
  logic [NS-1:0] slot_bad_o;
  logic [NS*AW-1:0] slot_addr_o;

  always #10 clk = ~clk;  // 50 MHz

  vl_insn_aligner #(.PARCELS(NP), .SLOTS(NS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fb_valid_i(fb_valid_i), .fb_ready_o(fb_ready_o), .fb_data_i(fb_data_i),
    .fb_addr_i(fb_addr_i), .fb_off_i(fb_off_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .slot_valid_o(slot_valid_o), .slot_insn_o(slot_insn_o),
    .slot_len_o(slot_len_o), .slot_bad_o(slot_bad_o), .slot_addr_o(slot_addr_o)
  );

  typedef struct { logic [15:0] p; logic [AW-1:0] a; int id; bit fresh; } ent_t;
  ent_t mq[$];
  logic [15:0] mem [MEMP];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic rnd(output logic [31:0] v);
    rs = nxt(rs); v = rs;
  endtask

  // length rule restated from the requirement text (R1, R2)
  function automatic int want_parcels(input logic [15:0] p);
    if (p[6:0] == 7'h7f) return 1;
    if (!(p[0] && p[1])) return 1;
    if (!(p[2] && p[3] && p[4])) return 2;
    if (p[5] == 1'b0) return 3;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run hung got %h exp %h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    int idx;
    int fp, off, pushes;
    bit first;
    bit prev_stall;
    logic [63:0] prev_insn;
    logic [AW-1:0] prev_addr;
    logic [31:0] r;

    // synthetic program stream mixing every length
    idx = 0;
    while (idx < MEMP) begin
      logic [15:0] p;
      int n;
      rnd(r); p = r[15:0];
      case (r[18:16])
        3'd0, 3'd1, 3'd2, 3'd3: begin if (p[1:0] == 2'b11) p[1:0] = 2'b01; n = 1; end
        3'd4, 3'd5: begin p[1:0] = 2'b11; if (p[4:2] == 3'b111) p[4:2] = 3'b011; n = 2; end
        3'd6: begin p[5:0] = 6'b011111; n = 3; end
        default: begin
          if (r[20]) begin p[6:0] = 7'b0111111; n = 4; end
          else begin p[6:0] = 7'h7f; n = 1; end
        end
      endcase
      mem[idx] = p;
      for (int j = 1; j < n; j++) begin
        rnd(r);
        if (idx + j < MEMP) mem[idx + j] = r[15:0];
      end
      idx += n;
    end

    // reset: R10
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R10", "out_valid in reset", 64'(out_valid_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid_o == 1'b0, "R10", "out_valid after reset", 64'(out_valid_o), 64'd0);
    chk(fb_ready_o == 1'b1, "R10", "fb_ready after reset", 64'(fb_ready_o), 64'd1);

    fp = 0; off = 0; first = 1; pushes = 0; prev_stall = 0;
    prev_insn = '0; prev_addr = '0;

    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit e_ready, e_valid, fire, acc, ok;
      bit e_v [NS];
      logic [63:0] e_insn [NS];
      logic [1:0] e_len [NS];
      bit e_bad [NS], e_split [NS], e_fresh [NS];
      logic [AW-1:0] e_addr [NS];
      int pos, n, used;

      @(negedge clk);
      // drive
      flush_i = (cyc % 97 == 50);
      if (flush_i) begin
        rnd(r); fp = int'(r[6:0]); off = int'(r[10:8]); first = 1;
      end
      rnd(r);
      if (cyc >= 2000)      begin fb_valid_i = 1'b1; out_ready_i = 1'b1; end
      else if (cyc >= 1000) begin fb_valid_i = r[1:0] != 0; out_ready_i = r[3:2] == 0; end
      else                  begin fb_valid_i = r[1:0] != 0; out_ready_i = r[3:2] != 0; end
      for (int j = 0; j < NP; j++) fb_data_i[16*j +: 16] = mem[(fp % NBLK) * NP + j];
      fb_addr_i = BASE + AW'(fp * 16);
      fb_off_i  = first ? 3'(off) : 3'd0;
      #2;

      // expectation from the model queue
      e_ready = !flush_i && (mq.size() <= NP);
      pos = 0; ok = !flush_i;
      for (int k = 0; k < NS; k++) begin
        e_v[k] = 0; e_insn[k] = '0; e_len[k] = '0; e_bad[k] = 0;
        e_split[k] = 0; e_fresh[k] = 0; e_addr[k] = '0;
        if (ok && pos < mq.size()) begin
          n = want_parcels(mq[pos].p);
          if (pos + n <= mq.size()) begin
            e_v[k] = 1;
            e_bad[k] = mq[pos].p[6:0] == 7'h7f;
            e_len[k] = e_bad[k] ? 2'd0 : 2'(n - 1);
            e_addr[k] = mq[pos].a;
            e_fresh[k] = mq[pos].fresh;
            for (int j = 0; j < n; j++) begin
              e_insn[k][16*j +: 16] = mq[pos + j].p;
              if (mq[pos + j].id != mq[pos].id) e_split[k] = 1;
            end
            pos += n;
          end else ok = 0;
        end else ok = 0;
      end
      used = pos;
      e_valid = e_v[0];

      if (flush_i) begin
        chk(out_valid_o == 1'b0, "R7", "out_valid during flush", 64'(out_valid_o), 64'd0);
        chk(fb_ready_o == 1'b0, "R7", "fb_ready during flush", 64'(fb_ready_o), 64'd0);
      end else begin
        chk(fb_ready_o == e_ready, "R8", "fb_ready", 64'(fb_ready_o), 64'(e_ready));
        chk(out_valid_o == e_valid, "R4", "out_valid", 64'(out_valid_o), 64'(e_valid));
        if (prev_stall && e_valid) begin
          chk(slot_insn_o[63:0] == prev_insn, "R9", "held slot0 insn", slot_insn_o[63:0], prev_insn);
          chk(slot_addr_o[AW-1:0] == prev_addr, "R9", "held slot0 addr",
              64'(slot_addr_o[AW-1:0]), 64'(prev_addr));
        end
        for (int k = 0; k < NS; k++) begin
          chk(slot_valid_o[k] == e_v[k], "R4", $sformatf("slot%0d valid", k),
              64'(slot_valid_o[k]), 64'(e_v[k]));
          if (e_v[k] && slot_valid_o[k]) begin
            chk(slot_len_o[2*k +: 2] == e_len[k], "R1", $sformatf("slot%0d len", k),
                64'(slot_len_o[2*k +: 2]), 64'(e_len[k]));
            chk(slot_bad_o[k] == e_bad[k], "R2", $sformatf("slot%0d illegal", k),
                64'(slot_bad_o[k]), 64'(e_bad[k]));
            chk(slot_insn_o[64*k +: 64] == e_insn[k], e_split[k] ? "R5" : "R3",
                $sformatf("slot%0d insn", k), slot_insn_o[64*k +: 64], e_insn[k]);
            chk(slot_addr_o[AW*k +: AW] == e_addr[k], e_fresh[k] ? "R6" : "R4",
                $sformatf("slot%0d addr", k), 64'(slot_addr_o[AW*k +: AW]), 64'(e_addr[k]));
          end
        end
      end

      fire = e_valid && out_ready_i;
      acc  = fb_valid_i && e_ready;
      prev_stall = e_valid && !out_ready_i && !flush_i;
      prev_insn  = slot_insn_o[63:0];
      prev_addr  = slot_addr_o[AW-1:0];

      @(posedge clk); #1;
      if (flush_i) mq.delete();
      else begin
        if (fire) repeat (used) void'(mq.pop_front());
        if (acc) begin
          for (int j = int'(fb_off_i); j < NP; j++) begin
            ent_t e;
            e.p = fb_data_i[16*j +: 16];
            e.a = fb_addr_i + AW'(2 * j);
            e.id = pushes;
            e.fresh = first;
            mq.push_back(e);
          end
          pushes++; fp++; first = 0;
        end
      end
    end
    finish_run();
  end

endmodule